// File: doc/BRIEF.md
# Region-Bounded Pair-Line Prefetcher

This block watches the stream of L1 fill events. Each time a block is filled, it checks whether the virtual address of the fill lies strictly inside a window that software has programmed. If it does, and prefetching is switched on, the block computes the other 32-byte line of the same aligned 64-byte pair from the fill's physical address. It then offers that line to L1 as a fetch request.

Software writes the two window bounds and an on/off switch through a small write-only configuration port. It can turn the switch on just before a code region that benefits and off again after it. The block holds at most one outstanding request. The request is offered with a valid/ready handshake. A qualifying fill that finds the slot still occupied is discarded and counted.

Fills that were themselves caused by this block's prefetches are flagged by the cache. They never start a new request, so prefetches cannot chain.

Top module: `pairline_prefetcher`

## Requirements
- R1: While reset is asserted and after its release, `reqValid` is 0 and `dropCount` is 0, and prefetching is off until it is enabled by a write.
- R2: A fill qualifies only when `lowBound < fillVaddr < highBound`, with both comparisons strict and unsigned. A fill whose virtual address equals either bound, or lies outside them, starts no request.
- R3: The request address is formed from `fillPaddr`. When bit 5 is 1 it is `fillPaddr - 0x20`, otherwise `fillPaddr + 0x20`, and bits 4:0 of the result are forced to 0.
- R4: A qualifying fill sampled at clock edge k makes `reqValid` 1 after edge k. While `reqReady` is 0, `reqValid` stays 1 and `reqAddr` does not change. The first edge that samples `reqReady` = 1 with no new load clears `reqValid`.
- R5: A configuration write (`cfgWe` = 1) selects its register with `cfgAddr`: 0 for the lower bound, 1 for the upper bound, and 2 for the enable, which is bit 0 of `cfgWdata`. A new value applies to fills from the next edge onward. While the enable is 0, no fill starts a request.
- R6: A fill with `fillFromPrefetch` = 1 never starts a request and is never counted as dropped.
- R7: A qualifying fill that arrives while `reqValid` = 1 and `reqReady` = 0 is dropped. `reqAddr` is kept, and `dropCount` rises by exactly 1 after that edge. Non-qualifying fills do not change `dropCount`.
- R8: A qualifying fill that arrives in the same cycle as an accepted handshake (`reqValid` = 1, `reqReady` = 1) loads a new request. `reqValid` stays 1 with the new address, and nothing is counted as dropped.
- R9: `dropCount` saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Register select: 0 lower bound, 1 upper bound, 2 enable |
| cfgWdata | input | VA_W | Configuration write data |
| fillValid | input | 1 | An L1 fill happens this cycle |
| fillVaddr | input | VA_W | Virtual address of the filled block |
| fillPaddr | input | PA_W | Physical address of the filled block |
| fillFromPrefetch | input | 1 | The fill was caused by this block's request |
| reqValid | output | 1 | A fetch request is offered |
| reqReady | input | 1 | L1 accepts the offered request |
| reqAddr | output | PA_W | Line-aligned physical address of the request |
| dropCount | output | CNT_W | Saturating count of discarded qualifying fills |

## Verification
Every result is registered once. A fill, a configuration write or a handshake driven before edge k shows its effect on `reqValid`, `reqAddr` or `dropCount` just after edge k. A configuration write therefore first affects a fill sampled at edge k+1. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge. The hold cases in R4 and R7 are sampled on several consecutive falling edges while `reqReady` stays low.

// File: rtl/pfp_pkg.sv
package pfp_pkg;

  typedef enum logic [1:0] {
    CFG_LOW  = 2'd0,
    CFG_HIGH = 2'd1,
    CFG_EN   = 2'd2
  } cfgSel_e;

  typedef struct packed {
    logic loadReq;   // capture a new partner address
    logic clearReq;  // handshake done, slot empties
    logic bumpDrop;  // qualifying fill discarded
  } pfpStrobe_t;

endpackage

// File: rtl/pfp_datapath.sv
module pfp_datapath
  import pfp_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int CNT_W     = 8,
  parameter int LINE_LOG2 = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [1:0]       cfgAddr,
  input  logic [VA_W-1:0]  cfgWdata,
  input  logic [VA_W-1:0]  fillVaddr,
  input  logic [PA_W-1:0]  fillPaddr,
  input  pfpStrobe_t       strb,
  output logic             inWindow,
  output logic             cfgEnable,
  output logic [PA_W-1:0]  reqAddr,
  output logic [CNT_W-1:0] dropCount
);

  localparam logic [PA_W-1:0]  LINE_STEP = PA_W'(1) << LINE_LOG2;
  localparam logic [PA_W-1:0]  LINE_MASK = LINE_STEP - PA_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};

  logic [VA_W-1:0] lowBound;
  logic [VA_W-1:0] highBound;
  logic [PA_W-1:0] pairSum;
  logic [PA_W-1:0] partnerAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowBound  <= '0;
      highBound <= '0;
      cfgEnable <= 1'b0;
    end else if (cfgWe) begin
      case (cfgAddr)
        CFG_LOW:  lowBound  <= cfgWdata;
        CFG_HIGH: highBound <= cfgWdata;
        CFG_EN:   cfgEnable <= cfgWdata[0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    inWindow = (fillVaddr > lowBound) && (fillVaddr < highBound);
  end

  always_comb begin
    if (fillPaddr[LINE_LOG2]) pairSum = fillPaddr - LINE_STEP;
    else                      pairSum = fillPaddr + LINE_STEP;
    partnerAddr = pairSum & ~LINE_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             reqAddr <= '0;
    else if (strb.loadReq) reqAddr <= partnerAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  dropCount <= '0;
    else if (strb.bumpDrop && dropCount != CNT_MAX) dropCount <= dropCount + CNT_W'(1);
  end

endmodule

// File: rtl/pfp_ctrl.sv
module pfp_ctrl
  import pfp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       fillValid,
  input  logic       fillFromPrefetch,
  input  logic       inWindow,
  input  logic       cfgEnable,
  input  logic       reqReady,
  output pfpStrobe_t strb,
  output logic       reqValid
);

  logic qualify;
  logic slotBusy;

  always_comb begin
    qualify       = fillValid && cfgEnable && !fillFromPrefetch && inWindow;
    slotBusy      = reqValid && !reqReady;
    strb.loadReq  = qualify && !slotBusy;
    strb.bumpDrop = qualify && slotBusy;
    strb.clearReq = reqValid && reqReady && !strb.loadReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              reqValid <= 1'b0;
    else if (strb.loadReq)  reqValid <= 1'b1;
    else if (strb.clearReq) reqValid <= 1'b0;
  end

endmodule

// File: rtl/pairline_prefetcher.sv
module pairline_prefetcher
  import pfp_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int CNT_W     = 8,
  parameter int LINE_LOG2 = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [1:0]       cfgAddr,
  input  logic [VA_W-1:0]  cfgWdata,
  input  logic             fillValid,
  input  logic [VA_W-1:0]  fillVaddr,
  input  logic [PA_W-1:0]  fillPaddr,
  input  logic             fillFromPrefetch,
  output logic             reqValid,
  input  logic             reqReady,
  output logic [PA_W-1:0]  reqAddr,
  output logic [CNT_W-1:0] dropCount
);

  pfpStrobe_t strb;
  logic       inWindow;
  logic       cfgEnable;

  pfp_ctrl u_ctrl (
    .clk              (clk),
    .rstN             (rstN),
    .fillValid        (fillValid),
    .fillFromPrefetch (fillFromPrefetch),
    .inWindow         (inWindow),
    .cfgEnable        (cfgEnable),
    .reqReady         (reqReady),
    .strb             (strb),
    .reqValid         (reqValid)
  );

  pfp_datapath #(
    .VA_W      (VA_W),
    .PA_W      (PA_W),
    .CNT_W     (CNT_W),
    .LINE_LOG2 (LINE_LOG2)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWe     (cfgWe),
    .cfgAddr   (cfgAddr),
    .cfgWdata  (cfgWdata),
    .fillVaddr (fillVaddr),
    .fillPaddr (fillPaddr),
    .strb      (strb),
    .inWindow  (inWindow),
    .cfgEnable (cfgEnable),
    .reqAddr   (reqAddr),
    .dropCount (dropCount)
  );

endmodule

// File: rtl/pfp_checker.sv
module pfp_checker #(
  parameter int PA_W      = 32,
  parameter int CNT_W     = 8,
  parameter int LINE_LOG2 = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             fillValid,
  input logic [PA_W-1:0]  fillPaddr,
  input logic             fillFromPrefetch,
  input logic             cfgEnable,
  input logic             reqValid,
  input logic             reqReady,
  input logic [PA_W-1:0]  reqAddr,
  input logic [CNT_W-1:0] dropCount
);

  assert_reset_R1: assert property (@(posedge clk) !rstN |=> !reqValid && dropCount == '0);

  assert_align_R3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> reqAddr[LINE_LOG2-1:0] == '0);

  assert_partner_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqValid) |-> (reqAddr[PA_W-1:LINE_LOG2+1] == $past(fillPaddr[PA_W-1:LINE_LOG2+1]))
                     && (reqAddr[LINE_LOG2] != $past(fillPaddr[LINE_LOG2])));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid && $stable(reqAddr));

  assert_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    fillValid && !cfgEnable && !reqValid |=> !reqValid);

  assert_nochain_R6: assert property (@(posedge clk) disable iff (!rstN)
    fillValid && fillFromPrefetch && !reqValid |=> !reqValid);

  assert_dropstep_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dropCount) |-> $past(reqValid && !reqReady)
                          && dropCount == CNT_W'($past(dropCount) + CNT_W'(1)));

endmodule

bind pairline_prefetcher pfp_checker #(
  .PA_W      (PA_W),
  .CNT_W     (CNT_W),
  .LINE_LOG2 (LINE_LOG2)
) u_chk (
  .clk              (clk),
  .rstN             (rstN),
  .fillValid        (fillValid),
  .fillPaddr        (fillPaddr),
  .fillFromPrefetch (fillFromPrefetch),
  .cfgEnable        (cfgEnable),
  .reqValid         (reqValid),
  .reqReady         (reqReady),
  .reqAddr          (reqAddr),
  .dropCount        (dropCount)
);

// File: tb/sim_pairline_prefetcher.sv
module sim_pairline_prefetcher;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic        fillValid = 1'b0;
  logic [31:0] fillVaddr = '0;
  logic [31:0] fillPaddr = '0;
  logic        fillFromPrefetch = 1'b0;
  logic        reqReady = 1'b0;
  logic        reqValid;
  logic [31:0] reqAddr;
  logic [7:0]  dropCount;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pairline_prefetcher u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .fillValid(fillValid), .fillVaddr(fillVaddr), .fillPaddr(fillPaddr),
    .fillFromPrefetch(fillFromPrefetch), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .dropCount(dropCount)
  );

  typedef struct packed {
    logic [31:0] va;
    logic [31:0] pa;
    logic        expV;
    logic [31:0] expA;
  } vec_t;

  // Window is (0x1000, 0x2000) during the table walk.
  localparam vec_t VECS [8] = '{
    '{32'h1500, 32'h0000_8040, 1'b1, 32'h0000_8060},
    '{32'h1500, 32'h0000_8060, 1'b1, 32'h0000_8040},
    '{32'h1000, 32'h0000_9000, 1'b0, 32'h0},
    '{32'h2000, 32'h0000_9000, 1'b0, 32'h0},
    '{32'h1001, 32'h0003_0077, 1'b1, 32'h0003_0040},
    '{32'h1FFF, 32'hABCD_E01F, 1'b1, 32'hABCD_E020},
    '{32'h0FFF, 32'h0000_9000, 1'b0, 32'h0},
    '{32'h3000, 32'h0000_9000, 1'b0, 32'h0}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // All drive tasks start and end on a falling edge.
  task automatic cfgWrite(input logic [1:0] a, input logic [31:0] d);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic fill(input logic [31:0] va, input logic [31:0] pa, input logic pf);
    fillValid = 1'b1; fillVaddr = va; fillPaddr = pa; fillFromPrefetch = pf;
    @(negedge clk);
    fillValid = 1'b0; fillFromPrefetch = 1'b0;
  endtask

  task automatic ackOne();
    reqReady = 1'b1;
    @(negedge clk);
    reqReady = 1'b0;
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reqValid in reset", 64'(reqValid), 64'd0);
    check("R1 dropCount in reset", 64'(dropCount), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reqValid after reset", 64'(reqValid), 64'd0);

    cfgWrite(2'd0, 32'h1000);
    cfgWrite(2'd1, 32'h2000);
    fill(32'h1500, 32'h8040, 1'b0);
    check("R1 R5 enable off at reset", 64'(reqValid), 64'd0);
    cfgWrite(2'd2, 32'h1);

    for (int i = 0; i < 8; i++) begin
      fill(VECS[i].va, VECS[i].pa, 1'b0);
      check("R2 window decision", 64'(reqValid), 64'(VECS[i].expV));
      if (VECS[i].expV) begin
        check("R3 partner address", 64'(reqAddr), 64'(VECS[i].expA));
        ackOne();
        check("R4 clears after ready", 64'(reqValid), 64'd0);
      end
    end

    fill(32'h1500, 32'h8040, 1'b1);
    check("R6 prefetch fill ignored", 64'(reqValid), 64'd0);
    check("R6 no drop counted", 64'(dropCount), 64'd0);

    fill(32'h1800, 32'h100, 1'b0);
    for (int i = 0; i < 3; i++) begin
      check("R4 held valid", 64'(reqValid), 64'd1);
      check("R4 held address", 64'(reqAddr), 64'h120);
      @(negedge clk);
    end

    fill(32'h1800, 32'h200, 1'b0);
    check("R7 drop counted", 64'(dropCount), 64'd1);
    check("R7 address kept", 64'(reqAddr), 64'h120);
    fill(32'h5000, 32'h200, 1'b0);
    check("R7 out-of-window not counted", 64'(dropCount), 64'd1);
    fill(32'h1800, 32'h200, 1'b1);
    check("R6 R7 prefetch fill not counted", 64'(dropCount), 64'd1);

    reqReady = 1'b1;
    fill(32'h1900, 32'h300, 1'b0);
    reqReady = 1'b0;
    check("R8 back-to-back valid", 64'(reqValid), 64'd1);
    check("R8 back-to-back address", 64'(reqAddr), 64'h320);
    check("R8 no drop", 64'(dropCount), 64'd1);
    ackOne();
    check("R8 cleared", 64'(reqValid), 64'd0);

    cfgWrite(2'd2, 32'h0);
    fill(32'h1500, 32'h8040, 1'b0);
    check("R5 disabled", 64'(reqValid), 64'd0);
    cfgWrite(2'd2, 32'h1);
    fill(32'h1500, 32'h8040, 1'b0);
    check("R5 re-enabled", 64'(reqValid), 64'd1);
    ackOne();
    cfgWrite(2'd0, 32'h1500);
    fill(32'h1500, 32'h8040, 1'b0);
    check("R5 R2 new lower bound", 64'(reqValid), 64'd0);

    fill(32'h1800, 32'h400, 1'b0);
    for (int i = 0; i < 260; i++) fill(32'h1800, 32'h500, 1'b0);
    check("R9 saturated", 64'(dropCount), 64'hFF);
    check("R9 R4 request kept", 64'(reqAddr), 64'h420);
    ackOne();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule